// File: doc/BRIEF.md
# SPI Master with Chip-Select Sequencing and Slave Ready Handshake

This block is a single-slave SPI master. A host hands it one word at a time over a valid/ready port. For each word the block lowers chip select and waits a programmable lead time. It then shifts the word out MSB first while capturing the word the slave returns. After the last clock edge it waits a phase-dependent lag before releasing chip select. All four combinations of clock polarity and clock phase are supported. The word length is programmable from 2 to 16 bits, and the serial clock rate comes from an 8-bit prescaler.

Two options change how words follow each other. With the hold option set, chip select stays low across consecutive words whenever the next word is already offered when the lag expires. In five-pin mode the slave drives an active-low ready line. The master synchronizes it and will not start the clock for any word, including a held follow-on word, while that line is high. This lets the slave stall the master after any word.

Top module: `spi_hs_master`

## Requirements
- R1: Out of reset and whenever chip select (`spi_cs_n`, active low) is high, `spi_cs_n` reads 1 and `spi_sclk` rests at the level of `cfg_cpol`. `tx_ready` reads 1 and `rx_valid` reads 0 in the idle state.
- R2: With `cfg_cpha`=0 the data bit is valid before the first clock edge and is sampled on odd edges. With `cfg_cpha`=1 the data bit changes on odd edges and is sampled on even edges. Words are sent and received MSB first. The clock finishes each word at the `cfg_cpol` level, so the final edge is falling for polarity 0 and rising for polarity 1.
- R3: `cfg_len` (2..16) sets the bit count. Only the low `cfg_len` bits of `tx_data` are sent. The received word appears in the low `cfg_len` bits of `rx_data`, and the bits above it are zero.
- R4: One bit period lasts 2×(`cfg_prescale`+1) clock cycles. The clock spends `cfg_prescale`+1 cycles at each level.
- R5: Chip select falls one cycle after a word is accepted from idle. The first clock edge follows `cfg_lead_dly`+1+(`cfg_prescale`+1) cycles after that fall, provided the slave is ready.
- R6: Chip select rises this many cycles after the final clock edge: (`cfg_prescale`+1 when `cfg_cpha`=0, else 0) + 1 + `cfg_lag_dly`.
- R7: When `cfg_hold`=1 and `tx_valid` is high as the lag expires, chip select stays low and the next word follows. Otherwise chip select rises after every word.
- R8: When `cfg_five_pin`=1 and `spi_rdy_n` is high, no clock edge is produced and chip select stays low. The word starts once `spi_rdy_n` goes low, after a two-stage synchronizer.
- R9: In hold mode the ready line is checked again before every follow-on word. A slave that raises `spi_rdy_n` after a word's final edge delays the next word's clock while chip select stays low.
- R10: `rx_valid` is a one-cycle strobe, one per word. `tx_ready` is high only in idle, or at lag expiry when `cfg_hold`=1.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock |
| rst | input | 1 | Synchronous active-high reset |
| cfg_cpol | input | 1 | Clock idle level |
| cfg_cpha | input | 1 | Clock phase select |
| cfg_five_pin | input | 1 | Honour the slave ready line |
| cfg_hold | input | 1 | Keep chip select low across queued words |
| cfg_prescale | input | 8 | Half bit period minus one, in clock cycles |
| cfg_len | input | 5 | Word length, 2..16 |
| cfg_lead_dly | input | 5 | Extra cycles from chip select fall to clock start |
| cfg_lag_dly | input | 5 | Extra cycles from final edge to chip select rise |
| tx_valid | input | 1 | Host offers a word |
| tx_ready | output | 1 | Block accepts the offered word |
| tx_data | input | 16 | Word to send, right-aligned |
| rx_valid | output | 1 | One-cycle strobe: received word ready |
| rx_data | output | 16 | Received word, right-aligned |
| spi_sclk | output | 1 | Serial clock |
| spi_cs_n | output | 1 | Chip select, active low |
| spi_mosi | output | 1 | Serial data to slave |
| spi_miso | input | 1 | Serial data from slave |
| spi_rdy_n | input | 1 | Slave ready, active low |

## Verification
Assertions check these properties on every cycle:
- While deselected, the clock rests at the polarity level.
- The receive strobe never lasts two cycles.
- Under the hold option, chip select rises only when no word was offered.
- `tx_ready` with chip select low implies the hold option.
- No clock edge follows directly on a chip-select fall.

Other behaviours only show up in the bench's sweep over modes, lengths, prescales and delays. These are the data ordering, the exact lead, lag and bit-period cycle counts, and the stalls that the ready line causes both before a first word and between held words.

// File: rtl/spi_hs_pkg.sv
package spi_hs_pkg;

    localparam int DEF_MAX_W = 16;
    localparam int DEF_PRE_W = 8;
    localparam int DEF_DLY_W = 5;

    typedef enum logic [1:0] {
        ST_IDLE,
        ST_SETUP,
        ST_SHIFT,
        ST_TAIL
    } seq_state_e;

    typedef struct packed {
        logic cpol;
        logic cpha;
        logic five_pin;
        logic hold;
    } mode_t;

    // Cycles after the final edge, minus one, before the chip-select decision.
    function automatic int unsigned lag_count(logic cpha, int unsigned half,
                                              int unsigned extra);
        return (cpha ? 0 : half) + extra;
    endfunction

endpackage

// File: rtl/spi_hs_sync.sv
module spi_hs_sync #(
    parameter int STAGES = 2
) (
    input  logic clk,
    input  logic rst,
    input  logic d,
    output logic q
);
    logic [STAGES-1:0] ff;

    always_ff @(posedge clk) begin
        if (rst) ff <= '1;
        else     ff <= {ff[STAGES-2:0], d};
    end

    assign q = ff[STAGES-1];
endmodule

// File: rtl/spi_hs_shifter.sv
module spi_hs_shifter #(
    parameter int MAX_W = 16,
    parameter int LEN_W = 5
) (
    input  logic             clk,
    input  logic             rst,
    input  logic             load,
    input  logic [MAX_W-1:0] tx_word,
    input  logic [LEN_W-1:0] len,
    input  logic             shift,
    input  logic             sample,
    input  logic             miso,
    output logic             mosi,
    output logic [MAX_W-1:0] rx_word
);
    logic [MAX_W-1:0] tx_sh;
    logic [MAX_W-1:0] rx_sh;

    always_ff @(posedge clk) begin
        if (rst) begin
            tx_sh <= '0;
            rx_sh <= '0;
        end else if (load) begin
            tx_sh <= tx_word << (MAX_W - int'(len));
            rx_sh <= '0;
        end else begin
            if (shift)  tx_sh <= tx_sh << 1;
            if (sample) rx_sh <= {rx_sh[MAX_W-2:0], miso};
        end
    end

    assign mosi    = tx_sh[MAX_W-1];
    assign rx_word = rx_sh;
endmodule

// File: rtl/spi_hs_seq.sv
module spi_hs_seq
    import spi_hs_pkg::*;
#(
    parameter int PRE_W = 8,
    parameter int DLY_W = 5,
    parameter int LEN_W = 5,
    parameter int CNT_W = 10
) (
    input  logic             clk,
    input  logic             rst,
    input  mode_t            mode,
    input  logic [PRE_W-1:0] prescale,
    input  logic [LEN_W-1:0] len,
    input  logic [DLY_W-1:0] lead_dly,
    input  logic [DLY_W-1:0] lag_dly,
    input  logic             tx_valid,
    input  logic             rdy_sync_n,
    output logic             tx_ready,
    output logic             load,
    output logic             shift,
    output logic             sample,
    output logic             done,
    output logic             sclk,
    output logic             cs_n
);
    seq_state_e       state;
    logic [CNT_W-1:0] cnt;
    logic [PRE_W-1:0] hcnt;
    logic [LEN_W:0]   ecnt;
    logic [LEN_W:0]   knum;
    logic             edge_now;
    logic             is_sample;
    logic             is_first;
    logic             is_last;
    logic             slave_ok;
    logic [CNT_W-1:0] lag_load;

    assign knum      = ecnt + 1'b1;
    assign edge_now  = (state == ST_SHIFT) && (hcnt == '0);
    assign is_sample = knum[0] ^ mode.cpha;
    assign is_first  = (knum == (LEN_W+1)'(1));
    assign is_last   = (knum == {len, 1'b0});
    assign slave_ok  = !mode.five_pin || !rdy_sync_n;
    assign lag_load  = CNT_W'(lag_count(mode.cpha, int'(prescale) + 1, int'(lag_dly)));

    assign tx_ready = (state == ST_IDLE) ||
                      ((state == ST_TAIL) && (cnt == '0) && mode.hold);
    assign load     = tx_valid && tx_ready;
    assign sample   = edge_now && is_sample;
    assign shift    = edge_now && !is_sample && !is_first;

    always_ff @(posedge clk) begin
        if (rst) begin
            state <= ST_IDLE;
            cnt   <= '0;
            hcnt  <= '0;
            ecnt  <= '0;
            sclk  <= mode.cpol;
            cs_n  <= 1'b1;
            done  <= 1'b0;
        end else begin
            done <= 1'b0;
            unique case (state)
                ST_IDLE: begin
                    sclk <= mode.cpol;
                    if (load) begin
                        cs_n  <= 1'b0;
                        cnt   <= CNT_W'(lead_dly);
                        state <= ST_SETUP;
                    end
                end
                ST_SETUP: begin
                    if (cnt != '0) begin
                        cnt <= cnt - 1'b1;
                    end else if (slave_ok) begin
                        hcnt  <= prescale;
                        ecnt  <= '0;
                        state <= ST_SHIFT;
                    end
                end
                ST_SHIFT: begin
                    if (hcnt != '0) begin
                        hcnt <= hcnt - 1'b1;
                    end else begin
                        sclk <= ~sclk;
                        hcnt <= prescale;
                        ecnt <= knum;
                        if (is_last) begin
                            cnt   <= lag_load;
                            done  <= 1'b1;
                            state <= ST_TAIL;
                        end
                    end
                end
                ST_TAIL: begin
                    if (cnt != '0) begin
                        cnt <= cnt - 1'b1;
                    end else if (mode.hold && tx_valid) begin
                        state <= ST_SETUP;
                    end else begin
                        cs_n  <= 1'b1;
                        state <= ST_IDLE;
                    end
                end
                default: state <= ST_IDLE;
            endcase
        end
    end
endmodule

// File: rtl/spi_hs_master.sv
module spi_hs_master
    import spi_hs_pkg::*;
#(
    parameter int MAX_W = DEF_MAX_W,
    parameter int PRE_W = DEF_PRE_W,
    parameter int DLY_W = DEF_DLY_W,
    localparam int LEN_W = $clog2(MAX_W + 1),
    localparam int CNT_W = ((PRE_W > DLY_W) ? PRE_W : DLY_W) + 2
) (
    input  logic             clk,
    input  logic             rst,
    input  logic             cfg_cpol,
    input  logic             cfg_cpha,
    input  logic             cfg_five_pin,
    input  logic             cfg_hold,
    input  logic [PRE_W-1:0] cfg_prescale,
    input  logic [LEN_W-1:0] cfg_len,
    input  logic [DLY_W-1:0] cfg_lead_dly,
    input  logic [DLY_W-1:0] cfg_lag_dly,
    input  logic             tx_valid,
    output logic             tx_ready,
    input  logic [MAX_W-1:0] tx_data,
    output logic             rx_valid,
    output logic [MAX_W-1:0] rx_data,
    output logic             spi_sclk,
    output logic             spi_cs_n,
    output logic             spi_mosi,
    input  logic             spi_miso,
    input  logic             spi_rdy_n
);
    mode_t mode;
    logic  rdy_sync_n;
    logic  load;
    logic  shift;
    logic  sample;

    assign mode = '{cpol: cfg_cpol, cpha: cfg_cpha,
                    five_pin: cfg_five_pin, hold: cfg_hold};

    spi_hs_sync #(.STAGES(2)) u_sync (
        .clk (clk),
        .rst (rst),
        .d   (spi_rdy_n),
        .q   (rdy_sync_n)
    );

    spi_hs_seq #(
        .PRE_W(PRE_W), .DLY_W(DLY_W), .LEN_W(LEN_W), .CNT_W(CNT_W)
    ) u_seq (
        .clk        (clk),
        .rst        (rst),
        .mode       (mode),
        .prescale   (cfg_prescale),
        .len        (cfg_len),
        .lead_dly   (cfg_lead_dly),
        .lag_dly    (cfg_lag_dly),
        .tx_valid   (tx_valid),
        .rdy_sync_n (rdy_sync_n),
        .tx_ready   (tx_ready),
        .load       (load),
        .shift      (shift),
        .sample     (sample),
        .done       (rx_valid),
        .sclk       (spi_sclk),
        .cs_n       (spi_cs_n)
    );

    spi_hs_shifter #(.MAX_W(MAX_W), .LEN_W(LEN_W)) u_shift (
        .clk     (clk),
        .rst     (rst),
        .load    (load),
        .tx_word (tx_data),
        .len     (cfg_len),
        .shift   (shift),
        .sample  (sample),
        .miso    (spi_miso),
        .mosi    (spi_mosi),
        .rx_word (rx_data)
    );
endmodule

// File: rtl/spi_hs_checker.sv
module spi_hs_checker (
    input logic clk,
    input logic rst,
    input logic cfg_cpol,
    input logic cfg_hold,
    input logic tx_valid,
    input logic tx_ready,
    input logic rx_valid,
    input logic spi_sclk,
    input logic spi_cs_n
);
    a_r1_idle_level: assert property (@(posedge clk) disable iff (rst)
        (spi_cs_n && $stable(cfg_cpol)) |-> (spi_sclk == cfg_cpol));

    a_r10_rx_strobe: assert property (@(posedge clk) disable iff (rst)
        rx_valid |=> !rx_valid);

    a_r7_hold_release: assert property (@(posedge clk) disable iff (rst)
        ($rose(spi_cs_n) && $past(cfg_hold)) |-> !$past(tx_valid));

    a_r10_ready_gap: assert property (@(posedge clk) disable iff (rst)
        (tx_ready && !spi_cs_n) |-> cfg_hold);

    a_r5_no_early_edge: assert property (@(posedge clk) disable iff (rst)
        $fell(spi_cs_n) |=> $stable(spi_sclk));
endmodule

bind spi_hs_master spi_hs_checker u_chk (
    .clk      (clk),
    .rst      (rst),
    .cfg_cpol (cfg_cpol),
    .cfg_hold (cfg_hold),
    .tx_valid (tx_valid),
    .tx_ready (tx_ready),
    .rx_valid (rx_valid),
    .spi_sclk (spi_sclk),
    .spi_cs_n (spi_cs_n)
);

// File: tb/spi_hs_master_tb.sv
`timescale 1ns/1ps
module spi_hs_master_tb_top;
    logic        clk = 1'b0;
    logic        rst = 1'b1;
    logic        cpol = 1'b0, cpha = 1'b0, five_pin = 1'b0, hold = 1'b0;
    logic [7:0]  pre = 8'd0;
    logic [4:0]  len = 5'd8;
    logic [4:0]  lead = 5'd0, lag = 5'd0;
    logic        tx_valid = 1'b0;
    logic [15:0] tx_data = '0;
    logic        tx_ready, rx_valid, spi_sclk, spi_cs_n, spi_mosi;
    logic [15:0] rx_data;
    logic        miso = 1'b0;
    logic        rdy_n = 1'b0;

    int checks = 0, failures = 0;
    int widx = 0, rx_n = 0, sidx = 0;
    int ecnt = 0, edge_total = 0, cs_rises = 0, cs_falls = 0;
    bit stall_after = 0;
    bit finished = 0;
    realtime t_csfall, t_csrise, t_first, t_second, t_last;
    logic [15:0] rx_log [64];
    logic [15:0] sl_got [64];
    logic [15:0] sl_rx = '0;

    always #2.5 clk = ~clk;

    spi_hs_master dut_i (
        .clk(clk), .rst(rst), .cfg_cpol(cpol), .cfg_cpha(cpha),
        .cfg_five_pin(five_pin), .cfg_hold(hold), .cfg_prescale(pre),
        .cfg_len(len), .cfg_lead_dly(lead), .cfg_lag_dly(lag),
        .tx_valid(tx_valid), .tx_ready(tx_ready), .tx_data(tx_data),
        .rx_valid(rx_valid), .rx_data(rx_data), .spi_sclk(spi_sclk),
        .spi_cs_n(spi_cs_n), .spi_mosi(spi_mosi), .spi_miso(miso),
        .spi_rdy_n(rdy_n)
    );

    function automatic logic [15:0] txw(int i);
        return 16'((i * 40503) ^ 23251);
    endfunction
    function automatic logic [15:0] slw(int i);
        return 16'((i * 7321) + 27701);
    endfunction
    function automatic logic [15:0] mk(int n);
        return 16'((32'd1 << n) - 1);
    endfunction

    task automatic chk(string req, logic [31:0] act, logic [31:0] exp);
        checks++;
        if (act !== exp) begin
            failures++;
            $display("FAIL %s: actual=%0h expected=%0h", req, act, exp);
        end
    endtask

    // Slave model: reacts to serial clock edges while selected.
    always @(negedge spi_cs_n) begin
        ecnt = 0;
        sl_rx = '0;
        t_csfall = $realtime;
        cs_falls++;
        miso = slw(sidx)[int'(len) - 1];
    end

    always @(posedge spi_cs_n) begin
        t_csrise = $realtime;
        cs_rises++;
    end

    always @(spi_sclk) begin
        if (spi_cs_n === 1'b0) begin
            int k;
            int n2;
            ecnt++;
            edge_total++;
            n2 = 2 * int'(len);
            k = ((ecnt - 1) % n2) + 1;
            if (k == 1) t_first = $realtime;
            if (k == 2) t_second = $realtime;
            if (((k % 2) == 1) != cpha) sl_rx = {sl_rx[14:0], spi_mosi};
            else if (k < n2) miso = slw(sidx)[int'(len) - 1 - k / 2];
            if (k == n2) begin
                sl_got[sidx] = sl_rx & mk(int'(len));
                sidx++;
                t_last = $realtime;
                if (!cpha) miso = slw(sidx)[int'(len) - 1];
                if (stall_after) rdy_n = 1'b1;
            end
        end
    end

    always @(negedge clk) begin
        if (rx_valid === 1'b1) begin
            rx_log[rx_n] = rx_data;
            rx_n++;
        end
    end

    task automatic send();
        tx_data = txw(widx);
        widx++;
        tx_valid = 1'b1;
        while (tx_ready !== 1'b1) @(negedge clk);
        @(negedge clk);
        tx_valid = 1'b0;
    endtask

    task automatic check_word(int w, int n);
        chk("R2 R3 received word", 32'(rx_log[w]), 32'(slw(w) & mk(n)));
        chk("R2 R3 slave got word", 32'(sl_got[w]), 32'(txw(w) & mk(n)));
    endtask

    task automatic run_one(logic p, logic h, int n, int ps, int ld, int lg);
        int w;
        cpol = p; cpha = h; len = 5'(n); pre = 8'(ps);
        lead = 5'(ld); lag = 5'(lg); five_pin = 0; hold = 0;
        repeat (2) @(negedge clk);
        w = widx;
        send();
        @(posedge spi_cs_n);
        repeat (2) @(negedge clk);
        check_word(w, n);
        chk("R4 half period", 32'(int'((t_second - t_first) / 5.0)), 32'(ps + 1));
        chk("R5 lead cycles", 32'(int'((t_first - t_csfall) / 5.0)), 32'(ld + 1 + ps + 1));
        chk("R6 lag cycles", 32'(int'((t_csrise - t_last) / 5.0)),
            32'((h ? 0 : ps + 1) + 1 + lg));
        chk("R2 final level", 32'(spi_sclk), 32'(p));
    endtask

    initial begin
        int lens [3] = '{2, 7, 16};
        int w0, r0, f0, e0;
        repeat (5) @(negedge clk);
        rst = 1'b0;
        @(negedge clk);
        cs_rises = 0; cs_falls = 0;
        chk("R1 reset cs_n", 32'(spi_cs_n), 32'd1);
        chk("R1 reset sclk", 32'(spi_sclk), 32'(cpol));
        chk("R1 reset tx_ready", 32'(tx_ready), 32'd1);
        chk("R1 reset rx_valid", 32'(rx_valid), 32'd0);

        for (int md = 0; md < 4; md++)
            for (int li = 0; li < 3; li++)
                for (int pi = 0; pi < 2; pi++) begin
                    int n;
                    n = md * 6 + li * 2 + pi;
                    run_one(md[1], md[0], lens[li], pi * 2, n % 4, (n * 3) % 7);
                end
        run_one(1'b1, 1'b1, 3, 200, 2, 1);

        // R7: hold across three queued words
        cpol = 0; cpha = 1; len = 5; pre = 0; lead = 1; lag = 2; hold = 1;
        repeat (2) @(negedge clk);
        w0 = widx; r0 = cs_rises; f0 = cs_falls;
        send(); send(); send();
        @(posedge spi_cs_n);
        repeat (2) @(negedge clk);
        chk("R7 hold rises", 32'(cs_rises - r0), 32'd1);
        chk("R7 hold falls", 32'(cs_falls - f0), 32'd1);
        for (int i = 0; i < 3; i++) check_word(w0 + i, 5);

        // R7: no hold, chip select releases per word
        hold = 0;
        @(negedge clk);
        w0 = widx; r0 = cs_rises;
        send(); send(); send();
        @(posedge spi_cs_n);
        repeat (2) @(negedge clk);
        chk("R7 no-hold rises", 32'(cs_rises - r0), 32'd3);
        for (int i = 0; i < 3; i++) check_word(w0 + i, 5);

        // R8: slave not ready stalls the first word
        five_pin = 1; rdy_n = 1; cpha = 0; len = 9; pre = 1;
        repeat (4) @(negedge clk);
        w0 = widx; e0 = edge_total;
        send();
        repeat (40) @(negedge clk);
        chk("R8 no edges while stalled", 32'(edge_total - e0), 32'd0);
        chk("R8 cs held low", 32'(spi_cs_n), 32'd0);
        chk("R10 tx_ready low while busy", 32'(tx_ready), 32'd0);
        rdy_n = 0;
        @(posedge spi_cs_n);
        repeat (2) @(negedge clk);
        check_word(w0, 9);

        // R9: slave drops ready after a word in hold mode
        hold = 1; cpol = 1; cpha = 0; len = 6; pre = 1; lead = 0; lag = 4;
        repeat (4) @(negedge clk);
        w0 = widx; e0 = edge_total; r0 = cs_rises;
        stall_after = 1;
        send(); send();
        stall_after = 0;
        repeat (40) @(negedge clk);
        chk("R9 second word stalled", 32'(edge_total - e0), 32'd12);
        chk("R9 cs stays low", 32'(spi_cs_n), 32'd0);
        rdy_n = 0;
        @(posedge spi_cs_n);
        repeat (2) @(negedge clk);
        chk("R9 single release", 32'(cs_rises - r0), 32'd1);
        check_word(w0, 6);
        check_word(w0 + 1, 6);

        chk("R10 one strobe per word", 32'(rx_n), 32'(widx));
        finished = 1;
        $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
        $finish;
    end

    initial begin
        repeat (200000) @(posedge clk);
        if (!finished) begin
            checks++;
            failures++;
            $display("FAIL watchdog: actual=expired expected=done");
            $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
            $finish;
        end
    end
endmodule